// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Tags

This block receives one asynchronous serial channel. The line is brought into the clock domain through a short synchronizer and sampled on a 16x oversampling clock enable. A falling edge is confirmed as a start bit at its centre, and then each data bit, the optional parity bit and the stop bit are taken at their centres. Characters of 5, 6, 7 or 8 data bits arrive least significant bit first. Parity can be even, odd or absent.

Every completed character goes into a 16-entry queue together with three tags that describe that character alone: parity error, framing error and break. The oldest entry is shown on the read outputs, data and tags together, and a single pop strobe removes both. An interrupt request is raised while the fill count is at or above one of four selectable thresholds. If a character completes while the queue is full, the character is dropped and a sticky overrun flag is set. The flag stays set until the next pop.

Top module: `rx_tagged_fifo`

## Requirements
- R1: A low level on the line starts a character only if the line is still low on the 8th oversampling tick after the edge is detected. A shorter low pulse produces no entry and leaves the fill count unchanged.
- R2: Data bits are taken least significant bit first. `word_len` sets the length: 2'b00=5, 2'b01=6, 2'b10=7, 2'b11=8 bits. Bits above the length read as zero.
- R3: The queue holds 16 entries and returns them in arrival order. `fill` reports the number of stored entries, from 0 to 16.
- R4: With `par_en`=1, a parity bit follows the data. `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. A mismatch sets the entry's parity tag. With `par_en`=0 no parity bit is expected and the tag reads 0.
- R5: A stop bit sampled low sets the entry's framing tag.
- R6: A character whose data bits, parity bit (when present) and stop bit are all zero sets the break tag, together with the framing tag. The receiver then waits for the line to return high before it looks for a new start bit.
- R7: A character that completes while `fill`=16 is discarded, and `overrun` goes high. `overrun` stays high until a pop is accepted.
- R8: `irq` is high exactly when `fill` is at or above the threshold chosen by `trig_sel`: 2'b00=1, 2'b01=4, 2'b10=8, 2'b11=14.
- R9: The head entry's tags appear together with its data, and one `pop` removes both. When the queue is empty, data and tags read as zero and `pop` has no effect.
- R10: After reset, `fill`=0, `overrun`=0, `irq`=0 and the read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| os_tick | input | 1 | 16x oversampling clock enable |
| word_len | input | 2 | Data length code |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| trig_sel | input | 2 | Interrupt threshold code |
| pop | input | 1 | Remove head entry |
| rd_data | output | 8 | Head entry data |
| rd_par_err | output | 1 | Head entry parity tag |
| rd_frm_err | output | 1 | Head entry framing tag |
| rd_brk | output | 1 | Head entry break tag |
| fill | output | 5 | Stored entry count |
| overrun | output | 1 | Sticky discard flag |
| irq | output | 1 | Fill-threshold interrupt request |

## Verification
The in-line properties check the following on every clock:
- the fill count never exceeds the depth and moves by exactly one on an unopposed write;
- a discarded character always sets the overrun flag;
- a pop on an empty queue changes nothing;
- the decoder never issues back-to-back writes, and every break also carries a framing tag;
- unused upper data bits are zero;
- an empty queue never requests an interrupt.

Only the bench scenarios can show that serial frames decode to the right bytes, that each parity mode and length is honoured, that short start glitches are rejected, and that entries come out in arrival order with their own tags. The same applies to the four thresholds switching exactly at their fill values.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int unsigned DATA_MAX = 8;

   typedef struct packed {
      logic                brk;
      logic                frm;
      logic                par;
      logic [DATA_MAX-1:0] data;
   } rx_entry_t;

   typedef enum logic [2:0] {
      S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
   } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign line_out = line_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else if (STAGES == 1) chain_q <= line_in;
            else chain_q <= {chain_q[STAGES-2:0], line_in};
         end
         assign line_out = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rx_frame_decoder.sv
module rx_frame_decoder
   import uart_rx_pkg::*;
#(
   parameter int unsigned OVS = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rx_s,
   input  logic      tick,
   input  logic [1:0] word_len,
   input  logic      par_en,
   input  logic      par_odd,
   output logic      push,
   output rx_entry_t entry
);
   localparam int unsigned CNT_W = $clog2(OVS);
   localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

   generate
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two and at least 4");
      end
   endgenerate

   rx_state_t             state;
   logic [CNT_W-1:0]      cnt;
   logic [2:0]            bit_idx;
   logic [DATA_MAX-1:0]   shreg;
   logic                  par_bit;
   logic [2:0]            last_idx;
   logic [DATA_MAX-1:0]   aligned;
   logic                  par_expect;

   assign last_idx = {1'b0, word_len} + 3'd4;

   always_comb begin
      case (word_len)
         2'b00:   aligned = {3'b000, shreg[7:3]};
         2'b01:   aligned = {2'b00,  shreg[7:2]};
         2'b10:   aligned = {1'b0,   shreg[7:1]};
         default: aligned = shreg;
      endcase
   end

   assign par_expect = (^aligned) ^ par_odd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         par_bit <= 1'b0;
         push    <= 1'b0;
         entry   <= '0;
      end else begin
         push <= 1'b0;
         if (tick) begin
            case (state)
               S_IDLE: begin
                  if (!rx_s) begin
                     state <= S_START;
                     cnt   <= '0;
                  end
               end
               S_START: begin
                  if (cnt == MID) begin
                     cnt <= '0;
                     if (!rx_s) begin
                        state   <= S_DATA;
                        bit_idx <= '0;
                        par_bit <= 1'b0;
                     end else begin
                        state <= S_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_DATA: begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     shreg <= {rx_s, shreg[7:1]};
                     if (bit_idx == last_idx) state <= par_en ? S_PAR : S_STOP;
                     else bit_idx <= bit_idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_PAR: begin
                  if (cnt == LAST) begin
                     cnt     <= '0;
                     par_bit <= rx_s;
                     state   <= S_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_STOP: begin
                  if (cnt == LAST) begin
                     cnt        <= '0;
                     push       <= 1'b1;
                     entry.data <= aligned;
                     entry.par  <= par_en && (par_bit != par_expect);
                     entry.frm  <= !rx_s;
                     entry.brk  <= !rx_s && (aligned == '0) && !(par_en && par_bit);
                     state      <= rx_s ? S_IDLE : S_HOLD;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_HOLD: begin
                  if (rx_s) state <= S_IDLE;
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end

   assert_single_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !push);

   assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && word_len == 2'b00) |-> entry.data[7:5] == 3'b000);

   assert_break_frames_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && entry.brk) |-> entry.frm);
endmodule

// File: rtl/rx_tag_queue.sv
module rx_tag_queue
   import uart_rx_pkg::*;
#(
   parameter int unsigned DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  rx_entry_t                wr_entry,
   input  logic                     pop,
   output rx_entry_t                head,
   output logic [$clog2(DEPTH):0]   count,
   output logic                     overrun
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two and at least 2");
      end
   endgenerate

   rx_entry_t        mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic             full, empty, wr_ok, rd_ok;

   assign full  = (count == FULL_CNT);
   assign empty = (count == '0);
   assign wr_ok = push && !full;
   assign rd_ok = pop && !empty;

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr] <= wr_entry;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else begin
         if (wr_ok) wptr <= wptr + 1'b1;
         if (rd_ok) rptr <= rptr + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (push && full) overrun <= 1'b1;
         else if (rd_ok) overrun <= 1'b0;
      end
   end

   assign head = empty ? '0 : mem[rptr];

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);

   assert_fill_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !rd_ok) |=> count == $past(count) + 1'b1);

   assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> overrun);

   assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> count == '0);
endmodule

// File: rtl/rx_level_irq.sv
module rx_level_irq #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned LVL0  = 1,
   parameter int unsigned LVL1  = 4,
   parameter int unsigned LVL2  = 8,
   parameter int unsigned LVL3  = 14
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [$clog2(DEPTH):0] fill,
   input  logic [1:0]             trig_sel,
   output logic                   irq
);
   localparam int unsigned CW = $clog2(DEPTH) + 1;

   generate
      if (LVL0 < 1 || LVL1 < 1 || LVL2 < 1 || LVL3 < 1) begin : g_zero_lvl
         $error("threshold levels must be at least 1");
      end
      if (LVL0 > DEPTH || LVL1 > DEPTH || LVL2 > DEPTH || LVL3 > DEPTH) begin : g_big_lvl
         $error("threshold levels must not exceed DEPTH");
      end
   endgenerate

   logic [CW-1:0] level;

   always_comb begin
      case (trig_sel)
         2'b00:   level = CW'(LVL0);
         2'b01:   level = CW'(LVL1);
         2'b10:   level = CW'(LVL2);
         default: level = CW'(LVL3);
      endcase
   end

   assign irq = (fill >= level);

   assert_empty_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == '0) |-> !irq);
endmodule

// File: rtl/rx_tagged_fifo.sv
module rx_tagged_fifo
   import uart_rx_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OVS         = 16,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned LVL0        = 1,
   parameter int unsigned LVL1        = 4,
   parameter int unsigned LVL2        = 8,
   parameter int unsigned LVL3        = 14
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rx_line,
   input  logic                   os_tick,
   input  logic [1:0]             word_len,
   input  logic                   par_en,
   input  logic                   par_odd,
   input  logic [1:0]             trig_sel,
   input  logic                   pop,
   output logic [7:0]             rd_data,
   output logic                   rd_par_err,
   output logic                   rd_frm_err,
   output logic                   rd_brk,
   output logic [$clog2(DEPTH):0] fill,
   output logic                   overrun,
   output logic                   irq
);
   logic      rx_s;
   logic      push;
   rx_entry_t new_entry;
   rx_entry_t head;

   rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_in(rx_line), .line_out(rx_s));

   rx_frame_decoder #(.OVS(OVS)) u_dec (
      .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .tick(os_tick),
      .word_len(word_len), .par_en(par_en), .par_odd(par_odd),
      .push(push), .entry(new_entry));

   rx_tag_queue #(.DEPTH(DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n), .push(push), .wr_entry(new_entry),
      .pop(pop), .head(head), .count(fill), .overrun(overrun));

   rx_level_irq #(.DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)) u_irq (
      .clk(clk), .rst_n(rst_n), .fill(fill), .trig_sel(trig_sel), .irq(irq));

   assign rd_data    = head.data;
   assign rd_par_err = head.par;
   assign rd_frm_err = head.frm;
   assign rd_brk     = head.brk;
endmodule

// File: tb/rx_tagged_fifo_tb.sv
module rx_tagged_fifo_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       os_tick = 1'b0;
   logic [1:0] word_len = 2'b11;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic [1:0] trig_sel = 2'b00;
   logic       pop = 1'b0;
   logic [7:0] rd_data;
   logic       rd_par_err, rd_frm_err, rd_brk;
   logic [4:0] fill;
   logic       overrun, irq;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;
   always @(negedge clk) os_tick <= ~os_tick;

   rx_tagged_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
      .word_len(word_len), .par_en(par_en), .par_odd(par_odd),
      .trig_sel(trig_sel), .pop(pop), .rd_data(rd_data),
      .rd_par_err(rd_par_err), .rd_frm_err(rd_frm_err), .rd_brk(rd_brk),
      .fill(fill), .overrun(overrun), .irq(irq));

   // fields: len[24:23] pen[22] podd[21] data[20:13] badp[12] stop[11] exp[10:3] pe[2] fe[1] brk[0]
   localparam int NV = 9;
   localparam logic [24:0] VEC [NV] = '{
      {2'b11, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 3'b000},
      {2'b11, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b1, 8'h3C, 3'b000},
      {2'b11, 1'b1, 1'b1, 8'h3D, 1'b0, 1'b1, 8'h3D, 3'b000},
      {2'b10, 1'b1, 1'b0, 8'h7F, 1'b1, 1'b1, 8'h7F, 3'b100},
      {2'b00, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1, 8'h1F, 3'b000},
      {2'b01, 1'b1, 1'b1, 8'h2A, 1'b0, 1'b1, 8'h2A, 3'b000},
      {2'b11, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 8'h55, 3'b010},
      {2'b11, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 3'b011},
      {2'b11, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 3'b011}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hold_bit(input logic v);
      rx_line = v;
      repeat (32) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] d, input logic [1:0] len, input logic pen,
                            input logic podd, input logic badp, input logic stop_v);
      int nb = 5 + int'(len);
      logic [7:0] m = d & ((8'h1 << nb) - 8'h1);
      logic p = (^m) ^ podd ^ badp;
      @(negedge clk);
      hold_bit(1'b0);
      for (int i = 0; i < nb; i++) hold_bit(d[i]);
      if (pen) hold_bit(p);
      hold_bit(stop_v);
      rx_line = 1'b1;
      repeat (40) @(negedge clk);
   endtask

   task automatic do_pop();
      @(negedge clk); pop = 1'b1;
      @(negedge clk); pop = 1'b0;
   endtask

   function automatic int lvl_of(input int s);
      case (s)
         0: return 1;
         1: return 4;
         2: return 8;
         default: return 14;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R10 reset state
      chk("R10 fill", fill, 0);
      chk("R10 overrun", overrun, 0);
      chk("R10 irq", irq, 0);
      chk("R10 rd_data", rd_data, 0);

      // R1 short low pulse rejected
      rx_line = 1'b0;
      repeat (8) @(negedge clk);
      rx_line = 1'b1;
      repeat (400) @(negedge clk);
      chk("R1 glitch fill", fill, 0);

      // table walk: R2 R4 R5 R6 R9
      for (int v = 0; v < NV; v++) begin
         logic [24:0] e = VEC[v];
         word_len = e[24:23]; par_en = e[22]; par_odd = e[21];
         send_char(e[20:13], e[24:23], e[22], e[21], e[12], e[11]);
         chk("R3 fill after char", fill, 1);
         chk("R2 data", rd_data, e[10:3]);
         chk("R4 parity tag", rd_par_err, e[2]);
         chk("R5 framing tag", rd_frm_err, e[1]);
         chk("R6 break tag", rd_brk, e[0]);
         do_pop();
         chk("R9 pop removes entry", fill, 0);
         chk("R9 empty tags", {rd_par_err, rd_frm_err, rd_brk}, 0);
      end

      // R8 thresholds, R3 order, R7 overrun
      word_len = 2'b11; par_en = 1'b0; par_odd = 1'b0;
      for (int k = 1; k <= 17; k++) begin
         send_char(8'(k), 2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
         if (k <= 16) begin
            chk("R3 fill count", fill, k);
            chk("R7 no overrun yet", overrun, 0);
            for (int s = 0; s < 4; s++) begin
               trig_sel = 2'(s);
               #1;
               chk("R8 irq level", irq, (k >= lvl_of(s)) ? 1 : 0);
            end
         end
      end
      chk("R7 fill stays full", fill, 16);
      chk("R7 overrun set", overrun, 1);
      for (int k = 1; k <= 16; k++) begin
         chk("R3 order", rd_data, k);
         do_pop();
         if (k == 1) chk("R7 overrun cleared by pop", overrun, 0);
      end
      chk("R3 drained", fill, 0);
      chk("R9 empty data zero", rd_data, 0);
      do_pop();
      chk("R9 pop on empty ignored", fill, 0);
      trig_sel = 2'b00;
      #1;
      chk("R8 irq low when empty", irq, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule